// File: doc/BRIEF.md
# Standby DRAM refresh controller

This block keeps DRAM contents alive while the rest of the system is powered down. It runs from a timebase derived from the 32.768 kHz oscillator. One cycle of `clk_i` is one half-period of that oscillator, which lets the block offer a half-period refresh interval. While standby is in effect, a programmable interval timer fires and a CAS-before-RAS strobe sequence with fixed widths runs on every firing. The DRAM control pins, the address lines and the oscillator output are held at fixed active levels, so they do not float.

Each pin has a value output and an output-enable output. An output-enable of 0 means the pin is released to high impedance. Standby is in effect when power-good is low, power-sense is high and the internal standby-enable bit is set. That bit is loaded through a write strobe. The block clears the bit by itself when power-sense falls during power-down, and the block then stays idle as though it had been reset.

Top module: `sr_standby_refresh`

## Requirements
- R1: The 2-bit interval code on `ival_sel_i` sets the refresh interval in half-periods: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 16. The first CAS fall comes that many clock edges after standby begins. Later CAS falls are that many edges apart whenever the interval is at least 8.
- R2: Each refresh drives CAS low for one half-period. CAS and RAS are then low together for two half-periods. Both then rise in the same cycle and stay high for at least one precharge half-period.
- R3: A timer firing while a sequence runs is held pending. It starts a new sequence in the idle cycle that follows, and any further firings in the meantime merge into it. With codes 0 and 1, successive CAS falls are therefore 5 half-periods apart.
- R4: Refresh and pin driving happen only while power-good is low, power-sense is high and standby-enable is set. When any of these conditions is lost in the middle of a sequence, the pins are released at once.
- R5: When power-good and power-sense are both low at a clock edge, standby-enable clears. This clear wins over a simultaneous write of 1. Standby does not resume when power-sense returns high, until the bit is written again.
- R6: During standby, CAS0, RAS0, RAS1, RAS2, the write enable (held high) and address bits 0 to 9 (held high) are all driven.
- R7: CAS1, CAS2 and CAS3 are driven during standby only when `mras_i` is 1.
- R8: RAS3 is driven during standby only when `cfg4m_i` is 0. Address bit 10 is driven high during standby only when `cfg4m_i` is 1.
- R9: The oscillator output is driven low whenever power-good is low, whatever the state of standby-enable. It is released whenever power-good is high.
- R10: Outside standby, the output-enables of every strobe, of the write enable and of every address bit are 0.
- R11: `rst_ni` low clears standby-enable, the interval timer and the sequencer at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-period timebase (twice the 32.768 kHz rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the standby-enable bit |
| cfg_en_i | input | 1 | Value written to standby-enable |
| ival_sel_i | input | 2 | Refresh interval code |
| mras_i | input | 1 | Multiple-RAS mode; keeps CAS1 to CAS3 driven |
| cfg4m_i | input | 1 | 4MB DRAM configuration select |
| pwr_sense_i | input | 1 | Power-sense, must stay high for standby |
| pwr_good_i | input | 1 | Power-good; low means powered down |
| ras_n_o | output | 4 | RAS strobes, active low |
| ras_oe_o | output | 4 | Drive enables for the RAS strobes |
| cas_n_o | output | 4 | CAS strobes, active low |
| cas_oe_o | output | 4 | Drive enables for the CAS strobes |
| mwe_n_o | output | 1 | Memory write enable, active low |
| mwe_oe_o | output | 1 | Drive enable for the write enable |
| ma_o | output | 11 | Memory address lines |
| ma_oe_o | output | 11 | Drive enables for the address lines |
| osc_o | output | 1 | Oscillator output level |
| osc_oe_o | output | 1 | Drive enable for the oscillator output |

## Verification
Two events can fall in the same cycle: an interval-timer firing and a refresh sequence that is still running. The bench provokes this with interval codes 0 and 1, which are shorter than one sequence. It then judges the result by the spacing of CAS falls, which must settle at exactly 5 half-periods with no sequence lost or stretched. A second pairing is a power-sense drop at the same edge as a write of 1 to standby-enable. There, the clear must win, and the bench shows this through the output-enables staying low after power-sense returns.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned N_BANK   = 4;
  localparam int unsigned MA_W     = 11;
  localparam int unsigned MAX_HP   = 16;
  localparam int unsigned CNT_W    = $clog2(MAX_HP);
  localparam int unsigned CAS_LEAD = 1;
  localparam int unsigned RAS_HOLD = 2;
  localparam int unsigned PRE_HOLD = 1;
  localparam int unsigned DW_W     = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAS,
    ST_RAS,
    ST_PRE
  } seq_st_e;

  // interval in half-periods: code 0 -> 1, code n -> 2^(n+1)
  function automatic int unsigned ival_hp(input logic [SEL_W-1:0] sel);
    return (sel == '0) ? 1 : (2 << sel);
  endfunction
endpackage

// File: rtl/sr_interval_timer.sv
module sr_interval_timer
  import sr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, lim_m1;

  assign lim_m1 = CNT_W'(ival_hp(sel_i) - 1);
  // >= keeps a shrinking interval from overrunning the counter
  assign tick_o = !clr_i && (cnt_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  p_tick_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/sr_cbr_seq.sv
module sr_cbr_seq
  import sr_pkg::*;
#(
  parameter int unsigned CAS_HP = CAS_LEAD,
  parameter int unsigned RAS_HP = RAS_HOLD,
  parameter int unsigned PRE_HP = PRE_HOLD
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic cas_act_o,
  output logic ras_act_o,
  output logic busy_o
);
  seq_st_e         state_q, state_d;
  logic [DW_W-1:0] dwell_q, dwell_d, dwell_lim;
  logic            pend_q, pend_d, start, last;

  assign busy_o = (state_q != ST_IDLE);
  assign start  = !busy_o && (tick_i || pend_q);

  always_comb begin
    case (state_q)
      ST_CAS:  dwell_lim = DW_W'(CAS_HP - 1);
      ST_RAS:  dwell_lim = DW_W'(RAS_HP - 1);
      ST_PRE:  dwell_lim = DW_W'(PRE_HP - 1);
      default: dwell_lim = '0;
    endcase
  end
  assign last = (dwell_q == dwell_lim);

  always_comb begin
    state_d = state_q;
    dwell_d = dwell_q + 1'b1;
    if (clr_i) begin
      state_d = ST_IDLE;
      dwell_d = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          dwell_d = '0;
          if (start) state_d = ST_CAS;
        end
        ST_CAS: if (last) begin state_d = ST_RAS;  dwell_d = '0; end
        ST_RAS: if (last) begin state_d = ST_PRE;  dwell_d = '0; end
        ST_PRE: if (last) begin state_d = ST_IDLE; dwell_d = '0; end
        default: begin state_d = ST_IDLE; dwell_d = '0; end
      endcase
    end
  end

  // firings during a running sequence merge into one pending request
  always_comb begin
    pend_d = pend_q;
    if (clr_i)                 pend_d = 1'b0;
    else if (busy_o && tick_i) pend_d = 1'b1;
    else if (start)            pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dwell_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dwell_q <= dwell_d;
      pend_q  <= pend_d;
    end
  end

  assign cas_act_o = (state_q == ST_CAS) || (state_q == ST_RAS);
  assign ras_act_o = (state_q == ST_RAS);

  p_ras_after_cas_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_act_o) |-> $past(cas_act_o));
  p_pend_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && !clr_i) |=> pend_q);
  p_clr_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_o);
endmodule

// File: rtl/sr_pin_ctrl.sv
module sr_pin_ctrl
  import sr_pkg::*;
(
  input  logic              stby_i,
  input  logic              pd_i,
  input  logic              mras_i,
  input  logic              cfg4m_i,
  input  logic              cas_act_i,
  input  logic              ras_act_i,
  output logic [N_BANK-1:0] ras_n_o,
  output logic [N_BANK-1:0] ras_oe_o,
  output logic [N_BANK-1:0] cas_n_o,
  output logic [N_BANK-1:0] cas_oe_o,
  output logic              mwe_n_o,
  output logic              mwe_oe_o,
  output logic [MA_W-1:0]   ma_o,
  output logic [MA_W-1:0]   ma_oe_o,
  output logic              osc_o,
  output logic              osc_oe_o
);
  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    if (b == N_BANK - 1) begin : g_top_ras
      assign ras_oe_o[b] = stby_i && !cfg4m_i;
    end else begin : g_low_ras
      assign ras_oe_o[b] = stby_i;
    end
    if (b == 0) begin : g_cas0
      assign cas_oe_o[b] = stby_i;
    end else begin : g_casx
      assign cas_oe_o[b] = stby_i && mras_i;
    end
    assign ras_n_o[b] = !(ras_oe_o[b] && ras_act_i);
    assign cas_n_o[b] = !(cas_oe_o[b] && cas_act_i);
  end

  for (genvar i = 0; i < MA_W; i++) begin : g_ma
    if (i == MA_W - 1) begin : g_hi
      assign ma_oe_o[i] = stby_i && cfg4m_i;
    end else begin : g_lo
      assign ma_oe_o[i] = stby_i;
    end
    assign ma_o[i] = 1'b1;
  end

  assign mwe_n_o  = 1'b1;
  assign mwe_oe_o = stby_i;
  assign osc_o    = 1'b0;
  assign osc_oe_o = pd_i;
endmodule

// File: rtl/sr_standby_refresh.sv
module sr_standby_refresh
  import sr_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic         cfg_en_i,
  input  logic [1:0]   ival_sel_i,
  input  logic         mras_i,
  input  logic         cfg4m_i,
  input  logic         pwr_sense_i,
  input  logic         pwr_good_i,
  output logic [3:0]   ras_n_o,
  output logic [3:0]   ras_oe_o,
  output logic [3:0]   cas_n_o,
  output logic [3:0]   cas_oe_o,
  output logic         mwe_n_o,
  output logic         mwe_oe_o,
  output logic [10:0]  ma_o,
  output logic [10:0]  ma_oe_o,
  output logic         osc_o,
  output logic         osc_oe_o
);
  logic en_q, stby, sense_lost, tick, cas_act, ras_act, busy;

  assign sense_lost = !pwr_good_i && !pwr_sense_i;

  // sense loss wins over a write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_q <= 1'b0;
    else if (sense_lost) en_q <= 1'b0;
    else if (cfg_we_i)   en_q <= cfg_en_i;
  end

  assign stby = en_q && !pwr_good_i && pwr_sense_i;

  sr_interval_timer u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!stby),
    .sel_i  (ival_sel_i),
    .tick_o (tick)
  );

  sr_cbr_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!stby),
    .tick_i    (tick),
    .cas_act_o (cas_act),
    .ras_act_o (ras_act),
    .busy_o    (busy)
  );

  sr_pin_ctrl u_pins (
    .stby_i    (stby),
    .pd_i      (!pwr_good_i),
    .mras_i    (mras_i),
    .cfg4m_i   (cfg4m_i),
    .cas_act_i (cas_act),
    .ras_act_i (ras_act),
    .ras_n_o   (ras_n_o),
    .ras_oe_o  (ras_oe_o),
    .cas_n_o   (cas_n_o),
    .cas_oe_o  (cas_oe_o),
    .mwe_n_o   (mwe_n_o),
    .mwe_oe_o  (mwe_oe_o),
    .ma_o      (ma_o),
    .ma_oe_o   (ma_oe_o),
    .osc_o     (osc_o),
    .osc_oe_o  (osc_oe_o)
  );

  p_en_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_lost |=> !en_q);
  p_osc_pd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> (osc_oe_o && !osc_o));
  p_osc_rel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_good_i |-> !osc_oe_o);
  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_good_i |-> (ras_oe_o == '0 && cas_oe_o == '0 && !mwe_oe_o && ma_oe_o == '0));
  p_strobe_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (ras_n_o == '1 && cas_n_o == '1));
endmodule

// File: tb/sr_standby_refresh_test.sv
module sr_standby_refresh_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0, cfg_en = 1'b0;
  logic [1:0]  ival_sel = 2'd2;
  logic        mras = 1'b0, cfg4m = 1'b0;
  logic        ps = 1'b1, pg = 1'b1;
  logic [3:0]  ras_n, ras_oe, cas_n, cas_oe;
  logic        mwe_n, mwe_oe, osc, osc_oe;
  logic [10:0] ma, ma_oe;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  sr_standby_refresh uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
    .ival_sel_i(ival_sel), .mras_i(mras), .cfg4m_i(cfg4m),
    .pwr_sense_i(ps), .pwr_good_i(pg),
    .ras_n_o(ras_n), .ras_oe_o(ras_oe), .cas_n_o(cas_n), .cas_oe_o(cas_oe),
    .mwe_n_o(mwe_n), .mwe_oe_o(mwe_oe), .ma_o(ma), .ma_oe_o(ma_oe),
    .osc_o(osc), .osc_oe_o(osc_oe)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {pg, ps, en, mras, cfg4m, ras_oe[4], cas_oe[4], ma10_oe, mwe_oe, osc_oe}
  localparam logic [15:0] VEC [8] = '{
    {5'b11100, 4'b0000, 4'b0000, 3'b000},
    {5'b01100, 4'b1111, 4'b0001, 3'b011},
    {5'b01110, 4'b1111, 4'b1111, 3'b011},
    {5'b01101, 4'b0111, 4'b0001, 3'b111},
    {5'b01111, 4'b0111, 4'b1111, 3'b111},
    {5'b01011, 4'b0000, 4'b0000, 3'b001},
    {5'b00110, 4'b0000, 4'b0000, 3'b001},
    {5'b10111, 4'b0000, 4'b0000, 3'b000}
  };

  task automatic write_en(input logic v);
    pg = 1'b1; ps = 1'b1; cfg_we = 1'b1; cfg_en = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // returns posedges from standby entry to first CAS fall, and fall spacing
  task automatic timing(input logic [1:0] sel, output int first, output int period);
    int t0, t1;
    ival_sel = sel; mras = 1'b0; cfg4m = 1'b0;
    write_en(1'b1);
    @(negedge clk);
    t0 = cyc; pg = 1'b0;
    first = -1; period = -1; t1 = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (cas_n[0] == 1'b0) begin first = cyc - t0; t1 = cyc; break; end
    end
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (cas_n[0] == 1'b1) break;
    end
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (cas_n[0] == 1'b0) begin period = cyc - t1; break; end
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f, p;
    logic [15:0] v;
    logic [10:0] ma_exp;
    repeat (3) @(negedge clk);
    // R11: reset state
    check({ras_oe, cas_oe, ma_oe, mwe_oe, osc_oe} == '0, "R11 reset released",
          {ras_oe, cas_oe, ma_oe, mwe_oe, osc_oe}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // static pin levels: R6 R7 R8 R9 R10
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      mras = v[12]; cfg4m = v[11]; ival_sel = 2'd3;
      write_en(v[13]);
      pg = v[15]; ps = v[14];
      @(negedge clk);
      check({ras_oe, cas_oe, ma_oe[10], mwe_oe, osc_oe} == v[10:0],
            "R6/R7/R8/R9/R10 pin enables",
            {ras_oe, cas_oe, ma_oe[10], mwe_oe, osc_oe}, v[10:0]);
      ma_exp = {11{v[1]}};
      check(ma_oe[9:0] == ma_exp[9:0] && (!v[1] || (ma == '1 && mwe_n == 1'b1))
            && (!v[0] || osc == 1'b0), "R6 R9 held levels", {ma_oe, ma, mwe_n, osc}, {ma_exp, 11'h7ff, 2'b10});
    end

    // R1: interval and first latency
    timing(2'd2, f, p);
    check(f == 8 && p == 8, "R1 code2 first/period", {f[15:0], p[15:0]}, {16'd8, 16'd8});
    timing(2'd3, f, p);
    check(f == 16 && p == 16, "R1 code3 first/period", {f[15:0], p[15:0]}, {16'd16, 16'd16});
    // R3: firing while busy coalesces, 5 half-period spacing
    timing(2'd1, f, p);
    check(f == 4 && p == 5, "R3 code1 first/period", {f[15:0], p[15:0]}, {16'd4, 16'd5});
    timing(2'd0, f, p);
    check(f == 1 && p == 5, "R3 code0 first/period", {f[15:0], p[15:0]}, {16'd1, 16'd5});

    // R2: CBR pulse shape, sampled from a CAS fall
    timing(2'd2, f, p);
    begin
      logic [9:0] shp;
      shp[9:8] = {cas_n[0], ras_n[0]};
      for (int k = 1; k < 5; k++) begin
        @(negedge clk);
        shp[9-2*k -: 2] = {cas_n[0], ras_n[0]};
      end
      check(shp == 10'b01_00_00_11_11, "R2 cas-before-ras shape", shp, 10'b0100001111);
    end

    // R4: power-good rises mid-sequence -> released at once
    timing(2'd2, f, p);
    @(negedge clk);
    pg = 1'b1;
    #1;
    check(ras_oe == 0 && cas_oe == 0 && cas_n[0] == 1'b1, "R4 abort release",
          {ras_oe, cas_oe, cas_n}, 0 | 12'h00f);

    // R5: sense loss clears enable; beats simultaneous write
    timing(2'd2, f, p);
    cfg_we = 1'b1; cfg_en = 1'b1; ps = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; ps = 1'b1;
    repeat (20) @(negedge clk);
    check(ras_oe == 0 && cas_oe == 0 && mwe_oe == 0 && osc_oe == 1'b1,
          "R5 enable cleared, no resume", {ras_oe, cas_oe, mwe_oe, osc_oe}, 10'h001);
    check(cas_n == 4'hf, "R5 no refresh after clear", cas_n, 4'hf);
    // R4: enable rewritten with power on, standby resumes
    write_en(1'b1);
    pg = 1'b0;
    @(negedge clk);
    check(ras_oe == 4'hf && mwe_oe, "R4 resume after rewrite", {ras_oe, mwe_oe}, 5'h1f);

    // R11: reset in standby clears enable
    rst_ni = 1'b0;
    #1;
    check(ras_oe == 0 && osc_oe == 1'b1, "R11 async reset", {ras_oe, osc_oe}, 5'h01);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    check(ras_oe == 0 && cas_n == 4'hf, "R11 stays idle after reset", {ras_oe, cas_n}, 8'h0f);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule